// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Edge Interrupts

This block is a general-purpose pin controller on a simple word-wide register bus. Software sets which pins drive and what value they drive. Each driven pin can take its value from the output register or from a per-pin auxiliary signal. Pins that are not driven are sampled into an input register.

Each sampled pin can raise an edge interrupt. A per-pin polarity bit picks either the rising or the falling edge, and a per-pin enable bit masks it. Qualifying edges collect in a status register and drive a single level interrupt line.

Sampling and output updates happen on a "tick". A tick comes every system clock, or, when control selects it, on the chosen edge of an external sampling clock. That clock is first synchronized into the system domain.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, and `irq`, `pin_out`, `pin_oe` and `bus_ack` are low.
- R2: Registers are selected by word index on `bus_addr`: 0 input, 1 output, 2 output enable, 3 interrupt enable, 4 edge polarity, 5 auxiliary select, 6 control, 7 interrupt status. The control register keeps only bits [3:0] and reads zero above them: bit 0 selects the external clock, bit 1 selects its falling edge, bit 2 enables interrupts, bit 3 is the interrupt flag.
- R3: A write to word 0 (input) leaves the input register unchanged.
- R4: On each tick the output register becomes ((out & ~aux) | (aux_in & aux)) & oe. `pin_out` shows the output register and `pin_oe` the enable register.
- R5: On each tick the input register samples `pin_in & ~oe`. A read of word 0 returns input register OR output register.
- R6: With control bit 2 set, a pin whose polarity bit is 1 and whose enable bit is 1 flags an interrupt when its sampled value goes 0 to 1.
- R7: With polarity bit 0, the falling sampled edge flags the interrupt and the rising edge does not.
- R8: No interrupt is flagged for a pin whose interrupt enable bit is 0, or for any pin while control bit 2 is clear.
- R9: A flagged edge ORs its pin bit into the status register, sets control bit 3 and raises `irq`. Status bits accumulate across ticks.
- R10: A bus write to the status register replaces it. Writing zero while it was nonzero lowers `irq`.
- R11: With control bit 0 set and bit 1 clear, sampling happens only on a rising edge of `ext_clk` and not on its falling edge.
- R12: With control bits 0 and 1 set, sampling happens only on a falling edge of `ext_clk`.
- R13: An access is accepted when `bus_req` is high and `bus_ack` is low. `bus_ack` is high for exactly the next cycle, and read data is valid on `bus_rdata` while `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | WIDTH | Write data |
| bus_ack | output | 1 | One-cycle access acknowledge |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pin input levels |
| aux_in | input | WIDTH | Auxiliary output sources |
| ext_clk | input | 1 | External sampling clock (asynchronous) |
| pin_out | output | WIDTH | Output register value |
| pin_oe | output | WIDTH | Per-pin drive enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: WIDTH of 32 and a two-stage external-clock synchronizer. With 32 pins, the low half can be made outputs and the high half inputs in the same run. This lets the bench observe the auxiliary mux, the input masking and the OR-ed input read-back together. With two synchronizer stages, an `ext_clk` edge reaches the input register within three system cycles. The bench therefore waits a fixed six cycles and can show that a wrong-polarity edge produces no sample at all.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NREG   = 8;
  localparam int SEL_W  = 3;
  localparam int CTRL_W = 4;

  localparam int CB_ECLK  = 0;
  localparam int CB_NEG   = 1;
  localparam int CB_IEN   = 2;
  localparam int CB_IFLAG = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_IN    = 3'd0,
    SEL_OUT   = 3'd1,
    SEL_OE    = 3'd2,
    SEL_INTE  = 3'd3,
    SEL_PTRIG = 3'd4,
    SEL_AUX   = 3'd5,
    SEL_CTRL  = 3'd6,
    SEL_INTS  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic use_ext,
  input  logic neg_sel,
  output logic tick
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise_w;
  logic                   fall_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      last_q <= sync_q[TOP];
    end
  end

  assign rise_w = sync_q[TOP] & ~last_q;
  assign fall_w = ~sync_q[TOP] & last_q;
  assign tick   = use_ext ? (neg_sel ? fall_w : rise_w) : 1'b1;
endmodule

// File: rtl/gpio_edge_eval.sv
module gpio_edge_eval #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] curr,
  input  logic [WIDTH-1:0] polarity,
  input  logic [WIDTH-1:0] enable,
  input  logic             global_en,
  output logic [WIDTH-1:0] hit
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic went_up;
    logic went_down;
    assign went_up   = curr[i] & ~prev[i];
    assign went_down = prev[i] & ~curr[i];
    assign hit[i] = global_en & enable[i] & (polarity[i] ? went_up : went_down);
  end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic [SEL_W-1:0] addr,
  output logic [NREG-1:0]  wr_sel,
  output logic             rd_go,
  output logic             ack
);
  logic accept;

  assign accept = req & ~ack;
  assign rd_go  = accept & ~we;

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign wr_sel[k] = accept & we & (addr == SEL_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= accept;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [SEL_W-1:0] bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic             bus_ack,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] aux_in,
  input  logic             ext_clk,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             irq
);
  localparam int PAD_W = WIDTH - CTRL_W;

  logic [WIDTH-1:0]  in_q, out_q, oe_q, inte_q, ptrig_q, aux_q, ints_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_q;

  logic [WIDTH-1:0]  out_n, oe_n, inte_n, ptrig_n, aux_n, ints_n;
  logic [CTRL_W-1:0] ctrl_n;

  logic [WIDTH-1:0]  in_d, out_d, ints_d, in_s, hit_w;
  logic [CTRL_W-1:0] ctrl_d;
  logic              irq_d;

  logic [NREG-1:0]   wr_sel;
  logic              rd_go;
  logic              tick_w;
  logic              irq_clr_w;

  gpio_bus_port u_bus (
    .clk    (clk),
    .rst    (rst),
    .req    (bus_req),
    .we     (bus_we),
    .addr   (bus_addr),
    .wr_sel (wr_sel),
    .rd_go  (rd_go),
    .ack    (bus_ack)
  );

  gpio_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .ext_clk (ext_clk),
    .use_ext (ctrl_q[CB_ECLK]),
    .neg_sel (ctrl_q[CB_NEG]),
    .tick    (tick_w)
  );

  assign in_s = pin_in & ~oe_n;

  gpio_edge_eval #(.WIDTH(WIDTH)) u_edge (
    .prev      (in_q),
    .curr      (in_s),
    .polarity  (ptrig_n),
    .enable    (inte_n),
    .global_en (ctrl_n[CB_IEN]),
    .hit       (hit_w)
  );

  // Bus writes merged ahead of the tick update
  always_comb begin
    out_n   = wr_sel[SEL_OUT]   ? bus_wdata : out_q;
    oe_n    = wr_sel[SEL_OE]    ? bus_wdata : oe_q;
    inte_n  = wr_sel[SEL_INTE]  ? bus_wdata : inte_q;
    ptrig_n = wr_sel[SEL_PTRIG] ? bus_wdata : ptrig_q;
    aux_n   = wr_sel[SEL_AUX]   ? bus_wdata : aux_q;
    ctrl_n  = wr_sel[SEL_CTRL]  ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    ints_n  = wr_sel[SEL_INTS]  ? bus_wdata : ints_q;
  end

  assign irq_clr_w = wr_sel[SEL_INTS] & (bus_wdata == '0) & (ints_q != '0);

  always_comb begin
    in_d   = in_q;
    out_d  = out_n;
    ctrl_d = ctrl_n;
    ints_d = ints_n;
    irq_d  = irq_q;
    if (irq_clr_w) irq_d = 1'b0;
    if (tick_w) begin
      in_d  = in_s;
      out_d = ((out_n & ~aux_n) | (aux_in & aux_n)) & oe_n;
      if (hit_w != '0) begin
        ctrl_d[CB_IFLAG] = 1'b1;
        ints_d           = ints_n | hit_w;
        irq_d            = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= '0;
      out_q   <= '0;
      oe_q    <= '0;
      inte_q  <= '0;
      ptrig_q <= '0;
      aux_q   <= '0;
      ctrl_q  <= '0;
      ints_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      in_q    <= in_d;
      out_q   <= out_d;
      oe_q    <= oe_n;
      inte_q  <= inte_n;
      ptrig_q <= ptrig_n;
      aux_q   <= aux_n;
      ctrl_q  <= ctrl_d;
      ints_q  <= ints_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_go) begin
      case (reg_sel_e'(bus_addr))
        SEL_IN:    bus_rdata <= in_q | out_q;
        SEL_OUT:   bus_rdata <= out_q;
        SEL_OE:    bus_rdata <= oe_q;
        SEL_INTE:  bus_rdata <= inte_q;
        SEL_PTRIG: bus_rdata <= ptrig_q;
        SEL_AUX:   bus_rdata <= aux_q;
        SEL_CTRL:  bus_rdata <= {{PAD_W{1'b0}}, ctrl_q};
        default:   bus_rdata <= ints_q;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_ack,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic             irq,
  input logic             tick,
  input logic             wr_in,
  input logic [WIDTH-1:0] in_q,
  input logic [WIDTH-1:0] oe_q,
  input logic [WIDTH-1:0] ints_q,
  input logic             clr_ev
);
  p_ack_single_r13: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  p_ack_after_req_r13: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_req));

  p_in_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_in && !tick) |=> $stable(in_q));

  p_out_masked_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((pin_out & ~pin_oe) == '0));

  p_in_masked_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((in_q & oe_q) == '0));

  p_irq_status_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (ints_q != '0));

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(clr_ev));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_req (bus_req),
  .bus_ack (bus_ack),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .irq     (irq),
  .tick    (tick_w),
  .wr_in   (wr_sel[0]),
  .in_q    (in_q),
  .oe_q    (oe_q),
  .ints_q  (ints_q),
  .clr_ev  (irq_clr_w)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_req = 1'b0;
  logic         bus_we = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic         bus_ack;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] aux_in = '0;
  logic         ext_clk = 1'b0;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_oe;
  logic         irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .aux_in(aux_in),
    .ext_clk(ext_clk), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] idx, input logic [W-1:0] val);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = idx; bus_wdata = val;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] idx, output logic [W-1:0] val);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = idx;
    @(negedge clk);
    val = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [W-1:0] v;
    for (int k = 0; k < 8; k++) begin
      bus_read(3'(k), v);
      check($sformatf("R1 reset value of word %0d", k), v, '0);
    end
    check("R1 irq low after reset", {31'b0, irq}, '0);
    check("R1 pin_oe low after reset", pin_oe, '0);
    check("R1 pin_out low after reset", pin_out, '0);
  endtask

  task automatic test_ack();
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 3'd3;
    @(negedge clk);
    check("R13 ack one cycle after request", {31'b0, bus_ack}, 32'd1);
    bus_req = 1'b0;
    @(negedge clk);
    check("R13 ack lasts a single cycle", {31'b0, bus_ack}, '0);
  endtask

  task automatic test_regs();
    logic [W-1:0] v;
    bus_write(3'd3, 32'hA5A5_5A5A);
    bus_read(3'd3, v);  check("R2 interrupt enable readback", v, 32'hA5A5_5A5A);
    bus_write(3'd4, 32'h0F0F_F0F0);
    bus_read(3'd4, v);  check("R2 polarity readback", v, 32'h0F0F_F0F0);
    bus_write(3'd5, 32'h1357_9BDF);
    bus_read(3'd5, v);  check("R2 aux select readback", v, 32'h1357_9BDF);
    bus_write(3'd6, 32'hFFFF_FFF4);
    bus_read(3'd6, v);  check("R2 control keeps bits [3:0] only", v, 32'h0000_0004);
    bus_write(3'd3, '0);
    bus_write(3'd4, '0);
    bus_write(3'd5, '0);
    bus_write(3'd6, '0);
  endtask

  task automatic test_output();
    logic [W-1:0] v;
    aux_in = 32'h0000_00AB;
    bus_write(3'd2, 32'h0000_FFFF);
    check("R4 pin_oe follows enable register", pin_oe, 32'h0000_FFFF);
    bus_write(3'd1, 32'h1234_5678);
    check("R4 output masked by enable", pin_out, 32'h0000_5678);
    bus_read(3'd1, v);  check("R4 output register reads masked", v, 32'h0000_5678);
    bus_write(3'd5, 32'h0000_00FF);
    wait_cycles(1);
    check("R4 aux bits replace output bits", pin_out, 32'h0000_56AB);
    bus_write(3'd5, '0);
  endtask

  task automatic test_input();
    logic [W-1:0] v;
    set_pins(32'hCAFE_1234);
    bus_read(3'd0, v);  check("R5 input read is masked input OR output", v, 32'hCAFE_56AB);
    bus_write(3'd0, 32'hFFFF_FFFF);
    bus_read(3'd0, v);  check("R3 write to input word ignored", v, 32'hCAFE_56AB);
    set_pins('0);
  endtask

  task automatic test_rise();
    logic [W-1:0] v;
    bus_write(3'd4, 32'h0001_0000);
    bus_write(3'd3, 32'h0003_0000);
    bus_write(3'd6, 32'h0000_0004);
    set_pins(32'h0001_0000);
    check("R6 rising edge raises irq", {31'b0, irq}, 32'd1);
    bus_read(3'd7, v);  check("R6 status bit for rising pin", v, 32'h0001_0000);
    bus_read(3'd6, v);  check("R9 control flag bit set", v, 32'h0000_000C);
  endtask

  task automatic test_fall();
    logic [W-1:0] v;
    set_pins(32'h0003_0000);
    bus_read(3'd7, v);  check("R7 rising edge ignored with polarity 0", v, 32'h0001_0000);
    set_pins(32'h0001_0000);
    bus_read(3'd7, v);  check("R9 falling edge accumulates status", v, 32'h0003_0000);
    check("R9 irq stays high", {31'b0, irq}, 32'd1);
  endtask

  task automatic test_clear();
    logic [W-1:0] v;
    bus_write(3'd7, '0);
    check("R10 writing zero status lowers irq", {31'b0, irq}, '0);
    bus_read(3'd7, v);  check("R10 status replaced by write", v, '0);
  endtask

  task automatic test_mask();
    logic [W-1:0] v;
    set_pins(32'h0005_0000);
    set_pins(32'h0001_0000);
    check("R8 masked pin raises no irq", {31'b0, irq}, '0);
    bus_read(3'd7, v);  check("R8 masked pin sets no status", v, '0);
    bus_write(3'd6, '0);
    set_pins('0);
    set_pins(32'h0001_0000);
    check("R8 global disable raises no irq", {31'b0, irq}, '0);
    bus_read(3'd7, v);  check("R8 global disable sets no status", v, '0);
  endtask

  task automatic test_eclk();
    logic [W-1:0] v;
    bus_write(3'd6, 32'h0000_0001);
    set_pins(32'h0002_0000);
    wait_cycles(6);
    bus_read(3'd0, v);  check("R11 no sample without external edge", v, 32'h0001_56AB);
    ext_clk = 1'b1;
    wait_cycles(6);
    bus_read(3'd0, v);  check("R11 sample on external rising edge", v, 32'h0002_56AB);
    pin_in = 32'h0004_0000;
    ext_clk = 1'b0;
    wait_cycles(6);
    bus_read(3'd0, v);  check("R11 falling external edge ignored", v, 32'h0002_56AB);
  endtask

  task automatic test_nec();
    logic [W-1:0] v;
    bus_write(3'd6, 32'h0000_0003);
    ext_clk = 1'b1;
    wait_cycles(6);
    bus_read(3'd0, v);  check("R12 rising edge ignored in falling mode", v, 32'h0002_56AB);
    ext_clk = 1'b0;
    wait_cycles(6);
    bus_read(3'd0, v);  check("R12 sample on external falling edge", v, 32'h0004_56AB);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_ack();
    test_regs();
    test_output();
    test_input();
    test_rise();
    test_fall();
    test_clear();
    test_mask();
    test_eclk();
    test_nec();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule